// File: doc/BRIEF.md
# GPS Sentence Receiver with Field Splitter

This block listens to the asynchronous serial output of a satellite positioning receiver. It turns the ASCII sentence stream into a byte stream that a downstream consumer can use without any state of its own. The serial line carries 8 data bits, no parity and one stop bit, and runs at 4800 bit/s in the target system. A 16x oversampling receiver recovers each byte. A framing state machine then watches for the `$` that opens a sentence, numbers the comma-separated fields, and recognises the carriage-return/line-feed pair that closes the sentence.

Each recovered byte produces at most one strobe, and every strobe carries a field number. The strobe is one of: a sentence start, a data character, a field separator, a sentence end, or an error. Empty fields are legal, because some receivers leave fields blank. The separator strobe still fires for an empty field, so the consumer sees each field boundary even when no characters arrived in between. Checksums, sentence types and number conversion are left to the consumer.

Top module: `gps_sentence_rx`

## Requirements
- R1: The receiver decodes 8N1 frames with the least significant bit first. It counts 16 sample ticks per bit, with one tick every `OVS_DIV` clocks, and samples each data bit at its middle.
- R2: A low level that has gone high again by the middle of the start bit is rejected as a glitch and yields no output.
- R3: A byte whose stop bit samples low produces a one-cycle `err_frame_o` pulse and is dropped. The framer state and the field number stay unchanged.
- R4: While no sentence is open, every byte except `$` (0x24) is discarded and produces no strobe.
- R5: A `$` produces a one-cycle `sos_o` pulse with `fld_o` equal to 0, and opens a sentence at field 0.
- R6: Inside a sentence, a byte other than `$`, `,` (0x2C) and CR (0x0D) produces a one-cycle `dat_vld_o` pulse. `dat_o` carries the byte and `fld_o` carries the current field number.
- R7: A `,` inside a sentence produces a one-cycle `sep_o` pulse with `fld_o` equal to the number of the field being closed, then advances the field number by one. Two commas in a row therefore report an empty field.
- R8: The field number saturates at 31. Further commas report field 31 and leave it at 31.
- R9: A CR followed directly by LF (0x0A) produces a one-cycle `eos_o` pulse with `fld_o` equal to the last field number, and closes the sentence.
- R10: A CR followed by any byte other than LF produces a one-cycle `err_term_o` pulse. That byte is dropped and the sentence is closed.
- R11: A `$` inside an open sentence abandons it and starts a new sentence at field 0.
- R12: Under reset (`rst_n` low at a clock edge) all strobes and error outputs are low and no sentence is open.
- R13: At most one of the outputs `sos_o`, `dat_vld_o`, `sep_o`, `eos_o` and `err_term_o` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_i | input | 1 | Asynchronous serial line, idles high |
| sos_o | output | 1 | Sentence start strobe |
| dat_vld_o | output | 1 | Data character strobe |
| dat_o | output | 8 | Data character, valid with `dat_vld_o` |
| sep_o | output | 1 | Field separator strobe |
| eos_o | output | 1 | Sentence end strobe |
| fld_o | output | 5 | Field number accompanying a strobe |
| err_frame_o | output | 1 | Stop-bit error pulse |
| err_term_o | output | 1 | Terminator error pulse |

## Verification
The bench focuses on these corner cases:

- **Empty fields.** Two commas in a row must report two separators with consecutive field numbers. A design that only advanced the field number on data would report the same number twice.
- **Restarting `$`.** A `$` arriving mid-sentence must bring the field number back to 0. A design that ignored it would keep numbering fields from the old sentence.
- **Dropped bytes.** A byte with a bad stop bit, and a byte following a lone CR, must both vanish without shifting later field numbers. A design that let either through would emit an extra data strobe, or skip an idle state that should have discarded later characters.
- **Field saturation and glitches.** Thirty-three commas probe the field number limit, where a wrapping counter would fall back to 0. A short low pulse on the line probes start-bit rejection, where a design without the mid-bit check would decode a phantom byte.

// File: rtl/gps_rx_pkg.sv
// Shared types and character codes for the sentence receiver.
// Assumes ASCII framing characters; no other package dependencies.
package gps_rx_pkg;

    localparam int unsigned DATA_BITS = 8;

    localparam logic [7:0] CH_START = 8'h24;  // '$'
    localparam logic [7:0] CH_COMMA = 8'h2C;  // ','
    localparam logic [7:0] CH_CR    = 8'h0D;
    localparam logic [7:0] CH_LF    = 8'h0A;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_t;

    typedef enum logic [1:0] {
        FR_IDLE,
        FR_BODY,
        FR_CR
    } fr_state_t;

endpackage

// File: rtl/gps_uart_rx.sv
// Oversampling 8N1 serial receiver.
// Waits for a low level, confirms it at the middle of the start bit, then
// samples each data bit one bit time later (LSB first) and the stop bit.
// Assumes rx_i idles high; the prescaler restarts at every frame so the
// sample point drifts by at most one prescaler period.
module gps_uart_rx
    import gps_rx_pkg::*;
#(
    parameter int unsigned OVS_DIV = 651,  // clocks per oversample tick
    parameter int unsigned OVS     = 16    // ticks per bit
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_i,
    output logic       byte_vld,
    output logic [7:0] byte_q,
    output logic       frame_err
);

    localparam int unsigned PW   = (OVS_DIV > 1) ? $clog2(OVS_DIV) : 1;
    localparam int unsigned TW   = $clog2(OVS);
    localparam int unsigned HALF = OVS / 2;
    localparam int unsigned BW   = $clog2(DATA_BITS);

    logic [1:0]    sync_q;
    logic          rx_s;
    rx_state_t     st;
    logic [PW-1:0] presc;
    logic [TW-1:0] tcnt;
    logic [BW-1:0] bitn;
    logic [7:0]    shreg;

    assign rx_s   = sync_q[1];
    assign byte_q = shreg;

    // Bring the asynchronous line into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], rx_i};
    end

    // Frame state machine with prescaler and tick counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= RX_IDLE;
            presc     <= '0;
            tcnt      <= '0;
            bitn      <= '0;
            shreg     <= '0;
            byte_vld  <= 1'b0;
            frame_err <= 1'b0;
        end else begin
            byte_vld  <= 1'b0;
            frame_err <= 1'b0;
            if (st == RX_IDLE) begin
                presc <= '0;
                tcnt  <= '0;
                bitn  <= '0;
                if (!rx_s) st <= RX_START;
            end else if (presc != PW'(OVS_DIV - 1)) begin
                presc <= presc + 1'b1;
            end else begin
                presc <= '0;
                case (st)
                    RX_START: begin
                        if (tcnt == TW'(HALF - 1)) begin
                            tcnt <= '0;
                            st   <= rx_s ? RX_IDLE : RX_DATA;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                    RX_DATA: begin
                        if (tcnt == TW'(OVS - 1)) begin
                            tcnt  <= '0;
                            shreg <= {rx_s, shreg[7:1]};
                            if (bitn == BW'(DATA_BITS - 1)) st <= RX_STOP;
                            else                            bitn <= bitn + 1'b1;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                    default: begin
                        if (tcnt == TW'(OVS - 1)) begin
                            tcnt <= '0;
                            st   <= RX_IDLE;
                            if (rx_s) byte_vld  <= 1'b1;
                            else      frame_err <= 1'b1;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                endcase
            end
        end
    end

    // A frame ends either good or bad, never both.
    p_good_or_bad_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(byte_vld && frame_err));

    // Results come only out of the stop state.
    p_result_from_stop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld || frame_err) |-> $past(st) == RX_STOP);

    // A data phase is entered only after a low mid-start sample.
    p_start_confirmed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == RX_DATA && $past(st) == RX_START) |-> !$past(rx_s));

endmodule

// File: rtl/gps_framer.sv
// Sentence framer: turns received bytes into start, data, separator, end
// and terminator-error strobes, each tagged with a field number.
// Assumes at most one input byte per cycle; output is registered, one
// cycle after byte_vld.
module gps_framer
    import gps_rx_pkg::*;
#(
    parameter int unsigned FW = 5  // field number width
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          byte_vld,
    input  logic [7:0]    byte_d,
    output logic          sos,
    output logic          dvld,
    output logic [7:0]    dat,
    output logic          sep,
    output logic          eos,
    output logic          term_err,
    output logic [FW-1:0] fld
);

    localparam logic [FW-1:0] FLD_MAX = {FW{1'b1}};

    fr_state_t     fst;
    logic [FW-1:0] idx;

    // Classify each byte against the current framing state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fst      <= FR_IDLE;
            idx      <= '0;
            fld      <= '0;
            dat      <= '0;
            sos      <= 1'b0;
            dvld     <= 1'b0;
            sep      <= 1'b0;
            eos      <= 1'b0;
            term_err <= 1'b0;
        end else begin
            sos      <= 1'b0;
            dvld     <= 1'b0;
            sep      <= 1'b0;
            eos      <= 1'b0;
            term_err <= 1'b0;
            if (byte_vld) begin
                case (fst)
                    FR_IDLE: begin
                        if (byte_d == CH_START) begin
                            sos <= 1'b1;
                            idx <= '0;
                            fld <= '0;
                            fst <= FR_BODY;
                        end
                    end
                    FR_BODY: begin
                        if (byte_d == CH_START) begin
                            sos <= 1'b1;
                            idx <= '0;
                            fld <= '0;
                        end else if (byte_d == CH_CR) begin
                            fst <= FR_CR;
                        end else if (byte_d == CH_COMMA) begin
                            sep <= 1'b1;
                            fld <= idx;
                            if (idx != FLD_MAX) idx <= idx + 1'b1;
                        end else begin
                            dvld <= 1'b1;
                            dat  <= byte_d;
                            fld  <= idx;
                        end
                    end
                    default: begin
                        if (byte_d == CH_LF) begin
                            eos <= 1'b1;
                            fld <= idx;
                        end else begin
                            term_err <= 1'b1;
                        end
                        fst <= FR_IDLE;
                    end
                endcase
            end
        end
    end

    p_one_strobe_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sos, dvld, sep, eos, term_err}));

    p_start_at_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sos |-> fld == '0);

    p_strobe_needs_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sos || dvld || sep || eos || term_err) |-> $past(byte_vld));

    p_idle_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fst == FR_IDLE && !(byte_vld && byte_d == CH_START))
        |=> !(dvld || sep || eos || term_err));

    p_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (idx == FLD_MAX && !(byte_vld && byte_d == CH_START)) |=> idx == FLD_MAX);

endmodule

// File: rtl/gps_sentence_rx.sv
// Top level: serial receiver feeding the sentence framer.
// Assumes one clock domain; rx_i may be asynchronous.
module gps_sentence_rx
    import gps_rx_pkg::*;
#(
    parameter int unsigned OVS_DIV = 651,
    parameter int unsigned FW      = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_i,
    output logic          sos_o,
    output logic          dat_vld_o,
    output logic [7:0]    dat_o,
    output logic          sep_o,
    output logic          eos_o,
    output logic [FW-1:0] fld_o,
    output logic          err_frame_o,
    output logic          err_term_o
);

    logic       b_vld;
    logic [7:0] b_dat;

    gps_uart_rx #(.OVS_DIV(OVS_DIV), .OVS(16)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_i      (rx_i),
        .byte_vld  (b_vld),
        .byte_q    (b_dat),
        .frame_err (err_frame_o)
    );

    gps_framer #(.FW(FW)) u_fr (
        .clk      (clk),
        .rst_n    (rst_n),
        .byte_vld (b_vld),
        .byte_d   (b_dat),
        .sos      (sos_o),
        .dvld     (dat_vld_o),
        .dat      (dat_o),
        .sep      (sep_o),
        .eos      (eos_o),
        .term_err (err_term_o),
        .fld      (fld_o)
    );

endmodule

// File: tb/sim_gps_sentence_rx.sv
module sim_gps_sentence_rx;

    localparam int DIV = 4;
    localparam int BIT = 16 * DIV;

    // Vector: {byte, kind, field, stop_ok}
    // kind: 0 none, 1 start, 2 data, 3 separator, 4 end, 5 term err, 6 frame err
    localparam int NV = 23;
    localparam logic [16:0] VEC [NV] = '{
        {8'h41, 3'd0, 5'd0, 1'b1},  // R4 idle garbage
        {8'h24, 3'd1, 5'd0, 1'b1},  // R5
        {8'h47, 3'd2, 5'd0, 1'b1},  // R6, R1
        {8'h50, 3'd2, 5'd0, 1'b1},
        {8'h2C, 3'd3, 5'd0, 1'b1},  // R7
        {8'h2C, 3'd3, 5'd1, 1'b1},  // R7 empty field
        {8'h58, 3'd2, 5'd2, 1'b1},
        {8'h0D, 3'd0, 5'd0, 1'b1},
        {8'h0A, 3'd4, 5'd2, 1'b1},  // R9
        {8'h5A, 3'd0, 5'd0, 1'b1},  // R4
        {8'h24, 3'd1, 5'd0, 1'b1},
        {8'h41, 3'd2, 5'd0, 1'b1},
        {8'h2C, 3'd3, 5'd0, 1'b1},
        {8'h4B, 3'd2, 5'd1, 1'b1},
        {8'h24, 3'd1, 5'd0, 1'b1},  // R11 restart
        {8'h42, 3'd2, 5'd0, 1'b1},
        {8'h2C, 3'd3, 5'd0, 1'b1},
        {8'h43, 3'd6, 5'd0, 1'b0},  // R3
        {8'h44, 3'd2, 5'd1, 1'b1},  // R3 index unchanged
        {8'h0D, 3'd0, 5'd0, 1'b1},
        {8'h51, 3'd5, 5'd0, 1'b1},  // R10
        {8'h45, 3'd0, 5'd0, 1'b1},  // R10 back to idle
        {8'h2C, 3'd0, 5'd0, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx = 1'b1;
    logic       sos, dvld, sep, eos, ferr, terr;
    logic [7:0] dat;
    logic [4:0] fld;

    int n_chk = 0;
    int n_bad = 0;
    int ev_cnt = 0;
    int ev_kind = 0;
    int ev_fld = 0;
    int ev_dat = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    gps_sentence_rx #(.OVS_DIV(DIV), .FW(5)) u0 (
        .clk(clk), .rst_n(rst_n), .rx_i(rx),
        .sos_o(sos), .dat_vld_o(dvld), .dat_o(dat), .sep_o(sep),
        .eos_o(eos), .fld_o(fld), .err_frame_o(ferr), .err_term_o(terr)
    );

    // Record output events away from the active edge.
    always @(negedge clk) begin
        if (rst_n && (sos || dvld || sep || eos || terr || ferr)) begin
            ev_cnt <= ev_cnt + 1;
            ev_kind <= sos ? 1 : dvld ? 2 : sep ? 3 : eos ? 4 : terr ? 5 : 6;
            ev_fld <= fld;
            ev_dat <= dat;
        end
    end

    task automatic chk(input string req, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    function automatic string req_of(input int kind);
        case (kind)
            0: return "R4";
            1: return "R5";
            2: return "R6";
            3: return "R7";
            4: return "R9";
            5: return "R10";
            default: return "R3";
        endcase
    endfunction

    task automatic send(input logic [7:0] b, input logic stop_ok);
        @(negedge clk) rx = 1'b0;
        repeat (BIT) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx = b[i];
            repeat (BIT) @(negedge clk);
        end
        rx = stop_ok;
        repeat (BIT) @(negedge clk);
        rx = 1'b1;
        repeat (BIT) @(negedge clk);
    endtask

    task automatic expect_one(input string req, input int n0, input int kind, input int f);
        chk(req, ev_cnt, n0 + 1);
        chk(req, ev_kind, kind);
        chk(req, ev_fld, f);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        // R12: reset state
        chk("R12", {sos, dvld, sep, eos, ferr, terr}, 0);
        @(negedge clk) rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R12", {sos, dvld, sep, eos, ferr, terr}, 0);

        // Table walk: R1, R3..R7, R9..R11
        for (int v = 0; v < NV; v++) begin
            int n0, kind, f;
            n0 = ev_cnt;
            kind = int'(VEC[v][8:6]);
            f = int'(VEC[v][5:1]);
            send(VEC[v][16:9], VEC[v][0]);
            if (kind == 0) begin
                chk(req_of(kind), ev_cnt, n0);
            end else begin
                chk(req_of(kind), ev_cnt, n0 + 1);
                chk(req_of(kind), ev_kind, kind);
                if (kind >= 2 && kind <= 4) chk(req_of(kind), ev_fld, f);
                if (kind == 2) chk("R1", ev_dat, int'(VEC[v][16:9]));
            end
        end

        // R8: field number saturation over 33 commas
        begin
            int n0;
            n0 = ev_cnt;
            send(8'h24, 1'b1);
            expect_one("R8", n0, 1, 0);
            for (int k = 0; k < 33; k++) begin
                n0 = ev_cnt;
                send(8'h2C, 1'b1);
                expect_one("R8", n0, 3, (k > 31) ? 31 : k);
            end
            n0 = ev_cnt;
            send(8'h0D, 1'b1);
            send(8'h0A, 1'b1);
            expect_one("R8", n0, 4, 31);
        end

        // R2: short low glitch is rejected, receiver still works afterwards
        begin
            int n0;
            n0 = ev_cnt;
            @(negedge clk) rx = 1'b0;
            repeat (3 * DIV) @(negedge clk);
            rx = 1'b1;
            repeat (12 * BIT) @(negedge clk);
            chk("R2", ev_cnt, n0);
            send(8'h24, 1'b1);
            expect_one("R2", n0, 1, 0);
            n0 = ev_cnt;
            send(8'hA5, 1'b1);
            chk("R1", ev_dat, 8'hA5);
            chk("R1", ev_cnt, n0 + 1);
        end

        // R12: reset in the middle of a sentence closes it
        begin
            int n0;
            @(negedge clk) rst_n = 1'b0;
            repeat (3) @(negedge clk);
            chk("R12", {sos, dvld, sep, eos, ferr, terr}, 0);
            rst_n = 1'b1;
            n0 = ev_cnt;
            send(8'h31, 1'b1);
            chk("R12", ev_cnt, n0);
        end

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule